// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers every interrupt request that a small stack processor core can receive and turns them into one request and one vector. There are fourteen sources: a non-maskable pin, five general external pins, four stack limit faults, three timer zero-count events and a software trigger. The external pins pass through a two-stage synchronizer. The non-maskable pin is edge-detected and latched. The other external pins are level-sensitive. Internal events are single-cycle pulses that stay latched until the core takes them.

A mask register and a global enable bit gate the thirteen maskable sources. An external suppress pin holds off every maskable source, but it never holds off the non-maskable one. Among the sources that remain, a fixed priority picks the lowest index. The core sees `irq_req` and a vector. The vector is a software-set base with the winning source number placed below it. When the core raises `core_take`, the block answers with a one-cycle acknowledge. It also clears the winner's latch and stores the accepted vector in a readable register.

Software reaches the mask, control and accepted-vector registers through a simple register bus. Writes are strobed and reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` and `irq_ack` are 0, and the mask (address 0), the control register (address 1) and the accepted-vector register (address 2) all read 0. Address 3 always reads 0.
- R2: The source numbers are as follows. 0 is the non-maskable pin. 1 to 4 are `stk_fault[0..3]`. 5 to 9 are `ext_pin[0..4]`. 10 to 12 are `tmr_zero[0..2]`. 13 is software. Among the eligible sources, the lowest number wins.
- R3: Mask bit j (address 0, bits 12:0) enables source j+1 when it is 1. Control bit 0 is a global enable for all maskable sources. Neither of these affects source 0.
- R4: While the synchronized `suppress_pin` is high, no maskable source can raise `irq_req`, but source 0 still can.
- R5: External pins are level-sensitive. A change is seen at `irq_req` after two rising clock edges, and releasing a pin removes its request.
- R6: A rising edge on `nmi_pin` latches source 0 on the third edge after the change. The latch clears when the core takes it. Holding the pin high does not request again.
- R7: A one-cycle pulse on a stack fault or timer input latches its source on the next edge. The latch is kept while the source is masked, and it clears only when the core takes that source.
- R8: Writing control bit 1 as 1 latches the software source. Control bit 1 reads back as the software pending flag. Taking the software source clears it.
- R9: `irq_vec` = {control bits 15:5, winning source number (4 bits), 0}.
- R10: If `core_take` is high while `irq_req` is high, `irq_ack` is 1 for the following cycle. On that edge the winner's latch clears and the vector is copied into address 2. If `core_take` is high without a request, nothing happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Asynchronous non-maskable request, rising-edge triggered |
| ext_pin | input | 5 | Asynchronous level requests, sources 5 to 9 |
| suppress_pin | input | 1 | Asynchronous hold-off of maskable sources |
| stk_fault | input | 4 | Stack limit fault pulses, sources 1 to 4 |
| tmr_zero | input | 3 | Timer zero-count pulses, sources 10 to 12 |
| core_take | input | 1 | Core accepts the present request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector of the winning source |
| irq_ack | output | 1 | One-cycle acknowledge after acceptance |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
Several properties are checked on every cycle. An acknowledge never appears without a taken request. Under suppress, the only winner that can show up is source 0. A maskable winner always has its mask bit and the global enable set. Latches hold until they are cleared and are dropped on acknowledge. The accepted vector always matches the live one at the moment of the take. Only the bench's scenarios can show the synchronizer latency, the level versus edge behaviour of the pins, priority among several simultaneous sources, and masked events that are remembered and later delivered.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int NUM_SRC = 14;
    localparam int SRC_W   = 4;
    localparam int N_EXT   = 5;
    localparam int N_STK   = 4;
    localparam int N_TMR   = 3;
    localparam int DATA_W  = 16;
    localparam int BASE_W  = DATA_W - SRC_W - 1;
    localparam int N_MASK  = NUM_SRC - 1;

    localparam int IX_NMI  = 0;
    localparam int IX_STK0 = 1;
    localparam int IX_EXT0 = IX_STK0 + N_STK;
    localparam int IX_TMR0 = IX_EXT0 + N_EXT;
    localparam int IX_SW   = IX_TMR0 + N_TMR;

    typedef enum logic [1:0] {
        RA_MASK = 2'd0,
        RA_CTL  = 2'd1,
        RA_VEC  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
    } ctl_t;

    function automatic logic [DATA_W-1:0] make_vec(
        input logic [BASE_W-1:0] base, input logic [SRC_W-1:0] src);
        return {base, src, 1'b0};
    endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_latch.sv
`timescale 1ns/1ps
module irq_latch #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] pend_q
);
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= set | (pend_q & ~clr);
    end

    // R7: a pending bit not cleared stays set
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q & ~clr) & ~pend_q) == '0));
    // R7: an event pulse always lands in the latch
    a_r7_set_lands: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> (($past(set) & ~pend_q) == '0));
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
    parameter int N     = 14,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sw_pend,
    input  logic              take_ok,
    input  logic [DATA_W-1:0] live_vec,
    output logic [N_MASK-1:0] mask_q,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] vec_q,
    output logic              sw_set,
    output logic [DATA_W-1:0] rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    assign sw_set = wr && (sel == RA_CTL) && wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctl_q  <= '0;
            vec_q  <= '0;
        end else begin
            if (wr && sel == RA_MASK) mask_q <= wdata[N_MASK-1:0];
            if (wr && sel == RA_CTL) begin
                ctl_q.base <= wdata[DATA_W-1:DATA_W-BASE_W];
                ctl_q.en   <= wdata[0];
            end
            if (take_ok) vec_q <= live_vec;
        end
    end

    always_comb begin
        unique case (sel)
            RA_MASK: rdata = {{(DATA_W-N_MASK){1'b0}}, mask_q};
            RA_CTL:  rdata = {ctl_q.base, {(DATA_W-BASE_W-2){1'b0}}, sw_pend, ctl_q.en};
            RA_VEC:  rdata = vec_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic              suppress_pin,
    input  logic [N_STK-1:0]  stk_fault,
    input  logic [N_TMR-1:0]  tmr_zero,
    input  logic              core_take,
    output logic              irq_req,
    output logic [DATA_W-1:0] irq_vec,
    output logic              irq_ack,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int SYNC_W = N_EXT + 2;

    // synchronized pins: {suppress, ext, nmi}
    logic [SYNC_W-1:0] pin_s;
    logic              nmi_s, sup_s, nmi_prev, nmi_rise;
    logic [N_EXT-1:0]  ext_s;

    irq_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst),
        .din ({suppress_pin, ext_pin, nmi_pin}),
        .dout(pin_s)
    );
    assign nmi_s = pin_s[0];
    assign ext_s = pin_s[N_EXT:1];
    assign sup_s = pin_s[SYNC_W-1];

    always_ff @(posedge clk) begin
        if (rst) nmi_prev <= 1'b0;
        else     nmi_prev <= nmi_s;
    end
    assign nmi_rise = nmi_s & ~nmi_prev;

    // latch set and clear vectors
    logic [NUM_SRC-1:0] lat_set, lat_clr, lat_q, pending, enable, eligible, grant;
    logic [SRC_W-1:0]   win_idx;
    logic               any, take_ok, sw_set, ack_q;
    logic [N_MASK-1:0]  mask_q;
    ctl_t               ctl_q;
    logic [DATA_W-1:0]  vec_q;

    always_comb begin
        lat_set = '0;
        lat_set[IX_NMI] = nmi_rise;
        lat_set[IX_STK0 +: N_STK] = stk_fault;
        lat_set[IX_TMR0 +: N_TMR] = tmr_zero;
        lat_set[IX_SW] = sw_set;
    end

    assign take_ok = core_take & irq_req;
    assign lat_clr = take_ok ? grant : '0;

    irq_latch #(.WIDTH(NUM_SRC)) u_latch (
        .clk(clk), .rst(rst), .set(lat_set), .clr(lat_clr), .pend_q(lat_q)
    );

    // external level sources join the latched ones
    always_comb begin
        pending = lat_q;
        pending[IX_EXT0 +: N_EXT] = ext_s;
    end

    assign enable   = {mask_q & {N_MASK{ctl_q.en & ~sup_s}}, 1'b1};
    assign eligible = pending & enable;

    irq_prio #(.N(NUM_SRC), .IDX_W(SRC_W)) u_prio (
        .req(eligible), .grant(grant), .idx(win_idx), .any(any)
    );

    assign irq_req = any;
    assign irq_vec = make_vec(ctl_q.base, win_idx);

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= take_ok;
    end
    assign irq_ack = ack_q;

    irq_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .sw_pend(lat_q[IX_SW]), .take_ok(take_ok), .live_vec(irq_vec),
        .mask_q(mask_q), .ctl_q(ctl_q), .vec_q(vec_q), .sw_set(sw_set),
        .rdata(reg_rdata)
    );

    // R10: no acknowledge without a taken request
    a_r10_ack_needs_take: assert property (@(posedge clk) disable iff (rst)
        !(core_take && irq_req) |=> !irq_ack);
    // R10: accepted vector captured on take
    a_r10_vec_capture: assert property (@(posedge clk) disable iff (rst)
        (core_take && irq_req) |=> (vec_q == $past(irq_vec)));
    // R4: under suppress only source 0 can win
    a_r4_suppress: assert property (@(posedge clk) disable iff (rst)
        (sup_s && irq_req) |-> (win_idx == SRC_W'(IX_NMI)));
    // R3: a maskable winner is enabled
    a_r3_mask_ok: assert property (@(posedge clk) disable iff (rst)
        (irq_req && win_idx != SRC_W'(IX_NMI)) |-> (ctl_q.en && mask_q[win_idx - SRC_W'(1)]));
    // R6: taken NMI latch clears
    a_r6_nmi_clears: assert property (@(posedge clk) disable iff (rst)
        (core_take && irq_req && win_idx == SRC_W'(IX_NMI) && !nmi_rise) |=> !lat_q[IX_NMI]);
    // R8: taken software source clears
    a_r8_sw_clears: assert property (@(posedge clk) disable iff (rst)
        (core_take && irq_req && win_idx == SRC_W'(IX_SW) && !sw_set) |=> !lat_q[IX_SW]);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_pin = 1'b0, suppress_pin = 1'b0, core_take = 1'b0, reg_wr = 1'b0;
    logic [4:0]  ext_pin = '0;
    logic [3:0]  stk_fault = '0;
    logic [2:0]  tmr_zero = '0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        irq_req, irq_ack;
    logic [15:0] irq_vec, reg_rdata;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .ext_pin(ext_pin),
        .suppress_pin(suppress_pin), .stk_fault(stk_fault), .tmr_zero(tmr_zero),
        .core_take(core_take), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    localparam logic [10:0] BASE = 11'h123;
    localparam logic [15:0] CTL_ON  = {BASE, 5'b00001};
    localparam logic [15:0] CTL_OFF = {BASE, 5'b00000};

    function automatic logic [15:0] vexp(input int src);
        return {BASE, 4'(src), 1'b0};
    endfunction

    // {mask[12:0], ext[4:0], suppress, exp_req, exp_src[3:0]}
    localparam int NV = 9;
    localparam logic [23:0] TBL [NV] = '{
        {13'h1FFF, 5'b00001, 1'b0, 1'b1, 4'd5},
        {13'h1FFF, 5'b10100, 1'b0, 1'b1, 4'd7},
        {13'h1FFF, 5'b11000, 1'b0, 1'b1, 4'd8},
        {13'h1FEF, 5'b00011, 1'b0, 1'b1, 4'd6},
        {13'h0000, 5'b11111, 1'b0, 1'b0, 4'd0},
        {13'h1FFF, 5'b11111, 1'b1, 1'b0, 4'd0},
        {13'h1FFF, 5'b00000, 1'b0, 1'b0, 4'd0},
        {13'h0100, 5'b11111, 1'b0, 1'b1, 4'd9},
        {13'h1FFF, 5'b10000, 1'b0, 1'b1, 4'd9}
    };

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic take();
        core_take = 1'b1;
        tick();
        core_take = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 irq_req", 16'(irq_req), 16'd0);
        check("R1 irq_ack", 16'(irq_ack), 16'd0);
        rd_reg(2'd0, rd); check("R1 mask", rd, 16'h0);
        rd_reg(2'd1, rd); check("R1 ctl", rd, 16'h0);
        rd_reg(2'd2, rd); check("R1 vec reg", rd, 16'h0);
        rd_reg(2'd3, rd); check("R1 addr3", rd, 16'h0);

        // R2 R3 R4 R5 R9: table walk over level pins
        wr_reg(2'd1, CTL_ON);
        for (int k = 0; k < NV; k++) begin
            wr_reg(2'd0, {3'b000, TBL[k][23:11]});
            ext_pin = TBL[k][10:6];
            suppress_pin = TBL[k][5];
            tick(3);
            check($sformatf("R5 R3 R4 req entry %0d", k), 16'(irq_req), 16'(TBL[k][4]));
            if (TBL[k][4]) check($sformatf("R2 R9 vec entry %0d", k), irq_vec, vexp(int'(TBL[k][3:0])));
        end
        ext_pin = '0; suppress_pin = 1'b0;
        wr_reg(2'd0, 16'h1FFF);
        tick(3);
        check("R5 release", 16'(irq_req), 16'd0);

        // R7 R10 stack fault pulse, take and ack
        stk_fault = 4'b0010; tick(); stk_fault = '0;
        check("R7 stk req", 16'(irq_req), 16'd1);
        check("R2 stk vec", irq_vec, vexp(2));
        take();
        check("R10 ack", 16'(irq_ack), 16'd1);
        check("R10 cleared", 16'(irq_req), 16'd0);
        rd_reg(2'd2, rd); check("R10 vec captured", rd, vexp(2));
        tick();
        check("R10 ack one cycle", 16'(irq_ack), 16'd0);

        // R7 masked event is remembered
        wr_reg(2'd0, 16'h1FFD);
        stk_fault = 4'b0010; tick(); stk_fault = '0;
        tick();
        check("R7 masked no req", 16'(irq_req), 16'd0);
        wr_reg(2'd0, 16'h1FFF);
        check("R7 unmasked req", 16'(irq_req), 16'd1);
        check("R7 unmasked vec", irq_vec, vexp(2));
        take(); tick();

        // R2 simultaneous timer and stack events
        tmr_zero = 3'b001; stk_fault = 4'b1000; tick();
        tmr_zero = '0; stk_fault = '0;
        check("R2 stk beats timer", irq_vec, vexp(4));
        take();
        check("R7 timer remains req", 16'(irq_req), 16'd1);
        check("R7 timer vec", irq_vec, vexp(10));
        take();
        check("R7 timer cleared", 16'(irq_req), 16'd0);

        // R8 software source
        wr_reg(2'd1, CTL_ON | 16'h0002);
        check("R8 sw req", 16'(irq_req), 16'd1);
        check("R8 sw vec", irq_vec, vexp(13));
        rd_reg(2'd1, rd); check("R8 sw readback", rd, CTL_ON | 16'h0002);
        take();
        check("R8 sw cleared req", 16'(irq_req), 16'd0);
        rd_reg(2'd1, rd); check("R8 sw readback clear", rd, CTL_ON);

        // R3 global enable off
        wr_reg(2'd1, CTL_OFF);
        ext_pin = 5'b00001; tick(3);
        check("R3 global enable off", 16'(irq_req), 16'd0);

        // R6 R4 NMI ignores enable and suppress, edge only
        suppress_pin = 1'b1;
        nmi_pin = 1'b1; tick(2);
        check("R6 nmi not yet latched", 16'(irq_req), 16'd0);
        tick();
        check("R6 nmi req", 16'(irq_req), 16'd1);
        check("R6 nmi vec", irq_vec, vexp(0));
        take();
        check("R6 nmi ack", 16'(irq_ack), 16'd1);
        tick(3);
        check("R6 held high no rerequest", 16'(irq_req), 16'd0);
        nmi_pin = 1'b0; suppress_pin = 1'b0; tick(3);

        // R2 NMI over external pin
        wr_reg(2'd1, CTL_ON);
        tick(1);
        check("R2 ext alone", irq_vec, vexp(5));
        nmi_pin = 1'b1; tick(3);
        check("R2 nmi over ext", irq_vec, vexp(0));
        take();
        check("R2 ext after nmi", irq_vec, vexp(5));
        check("R2 ext after nmi req", 16'(irq_req), 16'd1);
        nmi_pin = 1'b0; ext_pin = '0; tick(3);

        // R10 take without request
        check("R10 idle", 16'(irq_req), 16'd0);
        take();
        check("R10 no ack without req", 16'(irq_ack), 16'd0);
        rd_reg(2'd2, rd); check("R10 vec reg kept", rd, vexp(0));

        done = 1;
        summary();
        $finish;
    end
endmodule